// File: doc/BRIEF.md
# Byte-wide non-volatile store register port

This block lets a CPU reach a 512-byte non-volatile data store through four byte-wide registers on a small register bus. Two registers hold a 9-bit byte address, one holds the data byte and one holds control and status. The store itself is modelled as a byte array.

Reads are started by setting a strobe in the control register. One cycle later, the addressed byte lands in the data register. A write needs two steps: first arm the port, then give a write strobe within a short window. After that the port stays busy for a parameterised number of cycles. This delay stands in for the slow physical programming time. At the end of that time the byte that was captured when the write started is committed to the store. A level interrupt tells the CPU that the store is ready.

Top module: `nv_byte_port`

## Requirements
- R1: After reset the data register (select 2) reads 0x00, the control register (select 3) reads 0x00 and `irq` is low.
- R2: Select 0 is the low address byte and select 1 the high address byte. Only bit 0 of the high byte is kept, and its bits 7..1 read 0. The byte address is {high[0], low}, so a high byte of 0x03 addresses the same bytes as 0x01.
- R3: The data register at select 2 can be written and read back from the bus.
- R4: In the control register, bits 7..4 always read 0. Bit 3 is the ready-interrupt enable and can be read and written. Bit 2 reads 1 while the port is armed. Bit 1 reads 1 while a write is in progress. Bit 0 reads 1 while a read is pending.
- R5: A control write with bit 0 set starts a read. Bit 0 reads 1 for one cycle. On the next cycle the data register holds the addressed byte.
- R6: A control write with bit 1 set, while the port is armed, starts a write. Bit 1 then reads 1 for exactly WRITE_CYCLES cycles. After that, the data and address present at the strobe are stored.
- R7: A control write with bit 2 set arms the port for 4 cycles. A write strobe accepted on the 4th cycle after arming starts a write. The arm bit self-clears after 4 cycles. A write strobe given later, or without arming, has no effect.
- R8: While a write is in progress, read strobes, write strobes and arm requests are ignored. Address and data registers can still be written.
- R9: `irq` equals control bit 3 AND NOT write-in-progress, as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 2 | Register select: 0 addr low, 1 addr high, 2 data, 3 control |
| busWrite | input | 1 | Write the selected register this cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Ready interrupt, level |

## Verification
The control block holds only a few counters, so a fault in any of them shows at the ports within one cycle or one write time:
- A wrong busy counter changes how many cycles bit 1 of the control register stays high, and the count is compared exactly.
- A wrong arm counter shifts the window edge, which is probed one cycle on each side.
- A snapshot taken at the wrong time stores a byte that the bus changed during the write, which a later read exposes.
- A busy flag that does not gate requests lets a read strobe overwrite the data register in the next cycle.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_DATA    = 2'd2;
  localparam logic [1:0] SEL_CTRL    = 2'd3;

  localparam int CB_RD = 0;
  localparam int CB_WR = 1;
  localparam int CB_ME = 2;
  localparam int CB_IE = 3;

  typedef struct packed {
    logic loadRead;
    logic startWrite;
    logic commitWrite;
  } nvpStrobe_t;
endpackage

// File: rtl/nvp_ctrl.sv
module nvp_ctrl
  import nvp_pkg::*;
#(
  parameter int WRITE_CYCLES = 5000,
  parameter int ARM_WINDOW   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busSel,
  input  logic       busWrite,
  input  logic [7:0] busWdata,
  output nvpStrobe_t strb,
  output logic [7:0] ctrlView,
  output logic       irq
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam int ARM_W = $clog2(ARM_WINDOW + 1);

  logic             irqEn;
  logic             busy;
  logic             rdPend;
  logic [CNT_W-1:0] cnt;
  logic [ARM_W-1:0] armCnt;
  logic             armed;
  logic             ctrlWr;
  logic             reqRead;
  logic             reqWrite;
  logic             reqArm;

  assign armed    = armCnt != '0;
  assign ctrlWr   = busWrite && (busSel == SEL_CTRL);
  assign reqRead  = ctrlWr && busWdata[CB_RD] && !busy;
  assign reqWrite = ctrlWr && busWdata[CB_WR] && !busy && armed;
  assign reqArm   = ctrlWr && busWdata[CB_ME] && !busy && !reqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn  <= 1'b0;
      busy   <= 1'b0;
      rdPend <= 1'b0;
      cnt    <= '0;
      armCnt <= '0;
    end else begin
      if (ctrlWr) irqEn <= busWdata[CB_IE];
      rdPend <= reqRead;
      if (reqWrite) begin
        busy   <= 1'b1;
        cnt    <= CNT_W'(WRITE_CYCLES - 1);
        armCnt <= '0;
      end else begin
        if (busy) begin
          if (cnt == '0) busy <= 1'b0;
          else           cnt  <= cnt - 1'b1;
        end
        if (reqArm)     armCnt <= ARM_W'(ARM_WINDOW);
        else if (armed) armCnt <= armCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb.loadRead    = rdPend;
    strb.startWrite  = reqWrite;
    strb.commitWrite = busy && (cnt == '0);
  end

  assign ctrlView = {4'b0000, irqEn, armed, busy, rdPend};
  assign irq      = irqEn && !busy;

  assert_read_pend_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[CB_RD] && !busy) |=> rdPend);
  assert_arm_needed_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(armed));
  assert_arm_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    armCnt <= ARM_W'(ARM_WINDOW));
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> busy);
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rdPend);
endmodule

// File: rtl/nvp_datapath.sv
module nvp_datapath
  import nvp_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busSel,
  input  logic       busWrite,
  input  logic [7:0] busWdata,
  input  nvpStrobe_t strb,
  output logic [7:0] addrLoView,
  output logic [7:0] addrHiView,
  output logic [7:0] dataView
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [7:0]        addrLo;
  logic [HI_W-1:0]   addrHi;
  logic [7:0]        dataReg;
  logic [ADDR_W-1:0] snapAddr;
  logic [7:0]        snapData;
  logic [7:0]        store [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        readByte;

  assign curAddr  = {addrHi, addrLo};
  assign readByte = store[curAddr];

  always_ff @(posedge clk) begin
    if (busWrite && busSel == SEL_ADDR_LO) addrLo <= busWdata;
    if (busWrite && busSel == SEL_ADDR_HI) addrHi <= busWdata[HI_W-1:0];
    if (strb.startWrite) begin
      snapAddr <= curAddr;
      snapData <= dataReg;
    end
    if (strb.commitWrite) store[snapAddr] <= snapData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                 dataReg <= 8'h00;
    else if (strb.loadRead)                    dataReg <= readByte;
    else if (busWrite && busSel == SEL_DATA)   dataReg <= busWdata;
  end

  assign addrLoView = addrLo;
  assign addrHiView = {{(8 - HI_W){1'b0}}, addrHi};
  assign dataView   = dataReg;

  assert_read_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRead |=> dataReg == $past(readByte));
endmodule

// File: rtl/nv_byte_port.sv
module nv_byte_port
  import nvp_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 5000,
  parameter int ARM_WINDOW   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busSel,
  input  logic       busWrite,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq
);
  nvpStrobe_t strb;
  logic [7:0] ctrlView;
  logic [7:0] addrLoView;
  logic [7:0] addrHiView;
  logic [7:0] dataView;

  nvp_ctrl #(.WRITE_CYCLES(WRITE_CYCLES), .ARM_WINDOW(ARM_WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWdata(busWdata), .strb(strb), .ctrlView(ctrlView), .irq(irq));

  nvp_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWdata(busWdata), .strb(strb), .addrLoView(addrLoView),
    .addrHiView(addrHiView), .dataView(dataView));

  always_comb begin
    case (busSel)
      SEL_ADDR_LO: busRdata = addrLoView;
      SEL_ADDR_HI: busRdata = addrHiView;
      SEL_DATA:    busRdata = dataView;
      default:     busRdata = ctrlView;
    endcase
  end

  assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctrlView[CB_WR]) && ctrlView[CB_IE]) |-> irq);
endmodule

// File: tb/test_nv_byte_port.sv
`timescale 1ns/1ps
module test_nv_byte_port;
  localparam int WCYC = 12;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busSel = 2'd0;
  logic busWrite = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic irq;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nv_byte_port #(.WRITE_CYCLES(WCYC)) i_nv_byte_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  // {isWrite, sel, wdata, expected}: R2, R3, R4 register behaviour
  localparam logic [18:0] VEC [12] = '{
    {1'b1, 2'd0, 8'h5A, 8'h00}, {1'b0, 2'd0, 8'h00, 8'h5A},
    {1'b1, 2'd1, 8'hFF, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h01},
    {1'b1, 2'd1, 8'h00, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b1, 2'd2, 8'hC3, 8'h00}, {1'b0, 2'd2, 8'h00, 8'hC3},
    {1'b1, 2'd3, 8'hF8, 8'h00}, {1'b0, 2'd3, 8'h00, 8'h08},
    {1'b1, 2'd3, 8'h00, 8'h00}, {1'b0, 2'd3, 8'h00, 8'h00}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    busSel = s; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    busSel = s; #1; v = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle(output int n);
    logic [7:0] v;
    n = 0;
    rd(2'd3, v);
    while (v[1] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(2'd3, v);
    end
  endtask

  task automatic readAt(input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] v);
    wr(2'd1, hi); wr(2'd0, lo); wr(2'd3, 8'h01); idle(1); rd(2'd2, v);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    idle(3);
    rstN = 1'b1;
    idle(1);
    rd(2'd2, v); chk("R1 data reset", v, 8'h00);
    rd(2'd3, v); chk("R1 ctrl reset", v, 8'h00);
    chk("R1 irq reset", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][17:16], v);
        chk($sformatf("R2/R3/R4 vector %0d", i), v, VEC[i][7:0]);
      end
    end

    // R6, R9: armed write, exact busy length
    wr(2'd0, 8'h10); wr(2'd1, 8'h00); wr(2'd2, 8'hA5);
    wr(2'd3, 8'h0C); wr(2'd3, 8'h0A);
    rd(2'd3, v); chk("R6 busy after strobe", v, 8'h0A);
    chk("R9 irq low while busy", {7'b0, irq}, 8'h00);
    waitIdle(n);
    chk("R6 busy length", 8'(n), 8'(WCYC));
    chk("R9 irq high when idle", {7'b0, irq}, 8'h01);

    // R5: read strobe timing
    wr(2'd2, 8'h00); wr(2'd3, 8'h09);
    rd(2'd3, v); chk("R5 pending bit", v, 8'h09);
    rd(2'd2, v); chk("R5 data not yet loaded", v, 8'h00);
    idle(1);
    rd(2'd2, v); chk("R5 data loaded", v, 8'hA5);
    rd(2'd3, v); chk("R5 pending self-clears", v, 8'h08);

    // R2: wrap of the high address byte
    wr(2'd1, 8'h01); wr(2'd0, 8'h10); wr(2'd2, 8'h3C);
    wr(2'd3, 8'h04); wr(2'd3, 8'h02); waitIdle(n);
    readAt(8'h03, 8'h10, v); chk("R2 high byte wraps", v, 8'h3C);
    readAt(8'h02, 8'h10, v); chk("R2 wrap to low half", v, 8'hA5);
    chk("R9 irq low when disabled", {7'b0, irq}, 8'h00);

    // R7: strobe on 4th cycle after arm accepted
    wr(2'd1, 8'h00); wr(2'd0, 8'h20); wr(2'd2, 8'h11);
    wr(2'd3, 8'h04); idle(3); wr(2'd3, 8'h02);
    rd(2'd3, v); chk("R7 last window cycle accepted", v, 8'h02);
    waitIdle(n);

    // R7: window expired
    wr(2'd2, 8'h22); wr(2'd3, 8'h04); idle(4);
    rd(2'd3, v); chk("R7 arm self-clears", v, 8'h00);
    wr(2'd3, 8'h02);
    rd(2'd3, v); chk("R7 late strobe ignored", v, 8'h00);
    readAt(8'h00, 8'h20, v); chk("R7 late strobe leaves store", v, 8'h11);

    // R7: no arm at all
    wr(2'd2, 8'h33); wr(2'd3, 8'h02);
    rd(2'd3, v); chk("R7 unarmed strobe ignored", v, 8'h00);
    readAt(8'h00, 8'h20, v); chk("R7 unarmed leaves store", v, 8'h11);

    // R8: requests ignored while busy; R6 snapshot
    wr(2'd0, 8'h30); wr(2'd2, 8'h44); wr(2'd3, 8'h04); wr(2'd3, 8'h02);
    wr(2'd0, 8'h20); wr(2'd2, 8'h99); wr(2'd3, 8'h01);
    rd(2'd3, v); chk("R8 read strobe ignored", v, 8'h02);
    idle(1);
    rd(2'd2, v); chk("R8 data kept while busy", v, 8'h99);
    wr(2'd3, 8'h04);
    rd(2'd3, v); chk("R8 arm ignored", v, 8'h02);
    wr(2'd3, 8'h02);
    waitIdle(n);
    rd(2'd3, v); chk("R8 no arm left after busy", v, 8'h00);
    readAt(8'h00, 8'h20, v); chk("R8 second strobe no write", v, 8'h11);
    readAt(8'h00, 8'h30, v); chk("R6 snapshot stored", v, 8'h44);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule